// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Software Force

This block gathers fifteen internal interrupt requests for a small embedded processor and turns them into one priority level. Each request pulse sets a bit in a pending register. A mask register gates the pending bits and a force register adds its own bits on top, so that software can raise any level for test even when no peripheral drives it. The encoder presents the highest unmasked level to the processor. The processor acknowledges a level, and that acknowledge clears the matching pending bit. Software can also clear pending bits on purpose through a write-only clear register.

In the intended system the two serial channels drive levels 4 and 5, one pulse per character sent or received. A separate serial error line pulses only on receive overflow. The real-time clock and the general-purpose timer supply the other hardware requests. There are no external interrupt pins and no configuration of request shape. All register accesses are single-cycle accesses over a simple select/write bus. Read data is combinational from the current register state.

Top module: `irq_force_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the pending, mask and force registers read 0 and `irq_level` is 0.
- R2: A 1 on `src_req[i]` (i from 1 to 15) in a cycle sets pending bit i at that clock edge. The bit stays set until it is cleared.
- R3: A mask bit of 1 keeps its level off `irq_level`. The pending bit still latches while it is masked and can be read.
- R4: A write to the clear register clears each pending bit whose data bit is 1 and leaves the bits written 0 untouched. The clear register reads as 0.
- R5: The force register is read-write. A forced, unmasked bit appears on `irq_level` with no pending bit set. The force register changes only when it is written.
- R6: `irq_level` is the highest-numbered bit that is pending or forced and not masked, so 15 wins over everything. It is 0 when no such bit exists.
- R7: An acknowledge of level N (`irq_ack`=1, `ack_level`=N) clears pending bit N at the clock edge after the edge that samples the acknowledge. The force register is not affected.
- R8: A request that arrives in the same cycle as a clear of its bit, by acknowledge or by a clear-register write, wins, and the bit stays pending.
- R9: Bit 0 of every register always reads 0. `src_req[0]` and data bit 0 of any write have no effect.
- R10: Register offsets on `bus_addr`: pending 0x48 (read-only, writes ignored), mask 0x4C, clear 0x50, force 0x54. Data occupies bits 15:0, upper data bits read 0, and any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr` |
| src_req | input | 16 | Hardware request pulses, bit i for level i |
| irq_ack | input | 1 | Processor acknowledges `ack_level` |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest active unmasked level, 0 for none |

## Verification
The assertions assume that `src_req` and the bus inputs are stable around the clock edge. They also assume that `ack_level` names a real level, 1 to 15, whenever `irq_ack` is high. Neither the clear check nor the request check holds if an acknowledge carries a level of 0 or a value that changes mid-cycle. The bench changes every input only on the falling edge, holds each request for exactly one cycle, and acknowledges only levels that are in range. It does this both while the level is pending and while it is only forced.

// File: rtl/irq_force_pkg.sv
package irq_force_pkg;
  localparam int NUM_LVL = 15;
  localparam int VEC_W   = NUM_LVL + 1;
  localparam int LVL_W   = $clog2(VEC_W);
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_CLEAR = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_FORCE = 8'h54;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] req,
  input  logic [VEC_W-1:0] clr,
  output logic [VEC_W-1:0] pend_q
);
  logic [VEC_W-1:0] pend_d;
  logic [VEC_W-1:0] req_v;
  logic [VEC_W-1:0] clr_v;

  assign req_v = {req[VEC_W-1:1], 1'b0};
  assign clr_v = {clr[VEC_W-1:1], 1'b0};

  // per-bit next state: a new request wins over any clear
  for (genvar i = 0; i < VEC_W; i++) begin : g_bit
    if (i == 0) begin : g_zero
      assign pend_d[i] = 1'b0;
    end else begin : g_live
      assign pend_d[i] = req_v[i] | (pend_q[i] & ~clr_v[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R2: every live request is latched at the edge
  p_req_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_v != '0) |=> ((pend_q & $past(req_v)) == $past(req_v)));

  // R4: a cleared bit without a competing request is gone
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v != '0) |=> ((pend_q & $past(clr_v) & ~$past(req_v)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int VEC_W = 16,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] active,
  output logic [LVL_W-1:0] level
);
  always_comb begin
    level = '0;
    for (int i = 1; i < VEC_W; i++) begin
      if (active[i]) level = LVL_W'(i);
    end
  end

  // R6: reported level is active and nothing above it is
  p_highest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> (active[level] && (((active >> level) >> 1) == '0)));

  // R6: no active bit gives level 0
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active[VEC_W-1:1] == '0) |-> (level == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int VEC_W  = 16,
  parameter int LVL_W  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [VEC_W-1:0]  pend_q,
  input  logic              irq_ack,
  input  logic [LVL_W-1:0]  ack_level,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [VEC_W-1:0]  mask_q,
  output logic [VEC_W-1:0]  force_q,
  output logic [VEC_W-1:0]  clr_vec
);
  import irq_force_pkg::*;

  localparam int PAD_W = DATA_W - VEC_W;

  logic             wr_mask, wr_force, wr_clear;
  logic [VEC_W-1:0] wdat_v;
  logic [VEC_W-1:0] mask_d, force_d;
  logic             ack_q;
  logic [LVL_W-1:0] ack_lvl_q;
  logic [VEC_W-1:0] ack_oh;
  logic             unused_hi;

  assign wdat_v    = {bus_wdata[VEC_W-1:1], 1'b0};
  assign unused_hi = ^bus_wdata[DATA_W-1:VEC_W];
  assign wr_mask   = bus_sel && bus_wr && (bus_addr == OFS_MASK);
  assign wr_force  = bus_sel && bus_wr && (bus_addr == OFS_FORCE);
  assign wr_clear  = bus_sel && bus_wr && (bus_addr == OFS_CLEAR);

  // next state with enables written out
  always_comb begin
    mask_d  = mask_q;
    force_d = force_q;
    if (wr_mask)  mask_d  = wdat_v;
    if (wr_force) force_d = wdat_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      force_q   <= '0;
      ack_q     <= 1'b0;
      ack_lvl_q <= '0;
    end else begin
      mask_q    <= mask_d;
      force_q   <= force_d;
      ack_q     <= irq_ack;
      ack_lvl_q <= ack_level;
    end
  end

  // registered acknowledge decoded to a one-hot clear
  always_comb begin
    ack_oh = '0;
    for (int i = 1; i < VEC_W; i++) begin
      ack_oh[i] = ack_q && (ack_lvl_q == LVL_W'(i));
    end
  end

  assign clr_vec = ack_oh | (wr_clear ? wdat_v : '0);

  always_comb begin
    unique case (bus_addr)
      OFS_PEND:  bus_rdata = {{PAD_W{1'b0}}, pend_q};
      OFS_MASK:  bus_rdata = {{PAD_W{1'b0}}, mask_q};
      OFS_FORCE: bus_rdata = {{PAD_W{1'b0}}, force_q};
      default:   bus_rdata = '0;
    endcase
  end

  // R5: force register holds unless written
  p_force_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_force |=> $stable(force_q));
endmodule

// File: rtl/irq_force_ctrl.sv
module irq_force_ctrl
  import irq_force_pkg::*;
#(
  parameter int P_VEC_W  = VEC_W,
  parameter int P_LVL_W  = LVL_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [P_ADDR_W-1:0] bus_addr,
  input  logic [P_DATA_W-1:0] bus_wdata,
  output logic [P_DATA_W-1:0] bus_rdata,
  input  logic [P_VEC_W-1:0]  src_req,
  input  logic                irq_ack,
  input  logic [P_LVL_W-1:0]  ack_level,
  output logic [P_LVL_W-1:0]  irq_level
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_i;
  logic [P_VEC_W-1:0] pend_q, mask_q, force_q, clr_vec, active;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  irq_regs #(
    .VEC_W(P_VEC_W), .LVL_W(P_LVL_W), .ADDR_W(P_ADDR_W), .DATA_W(P_DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_i),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pend_q(pend_q), .irq_ack(irq_ack), .ack_level(ack_level),
    .bus_rdata(bus_rdata), .mask_q(mask_q), .force_q(force_q), .clr_vec(clr_vec)
  );

  irq_pending #(.VEC_W(P_VEC_W)) u_pend (
    .clk(clk), .rst_n(rst_n_i), .req(src_req), .clr(clr_vec), .pend_q(pend_q)
  );

  assign active = (pend_q | force_q) & ~mask_q;

  irq_prio_enc #(.VEC_W(P_VEC_W), .LVL_W(P_LVL_W)) u_enc (
    .clk(clk), .rst_n(rst_n_i), .active(active), .level(irq_level)
  );

  // R3: a reported level is never a masked one
  p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (irq_level != '0) |-> !mask_q[irq_level]);
endmodule

// File: tb/irq_force_ctrl_tb_top.sv
module irq_force_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [15:0] wd;
    logic [15:0] req;
    logic        ack;
    logic [3:0]  alvl;
    logic [3:0]  elvl;
    logic [15:0] erd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 22;
  // fields: wr, addr, wdata, req, ack, ack_level, exp level, exp rdata, requirement
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h48, 16'h0000, 16'h0010, 1'b0, 4'd0, 4'd4,  16'h0010, 4'd2},  // R2 latch
    '{1'b1, 8'h4C, 16'h0010, 16'h0020, 1'b0, 4'd0, 4'd5,  16'h0010, 4'd3},  // R3 mask
    '{1'b0, 8'h48, 16'h0000, 16'h0000, 1'b0, 4'd0, 4'd5,  16'h0030, 4'd3},  // R3 latched while masked
    '{1'b1, 8'h4C, 16'h0030, 16'h0000, 1'b0, 4'd0, 4'd0,  16'h0030, 4'd3},  // R3 all masked
    '{1'b1, 8'h54, 16'h8001, 16'h0000, 1'b0, 4'd0, 4'd15, 16'h8000, 4'd5},  // R5 force, R9 bit0
    '{1'b1, 8'h50, 16'h0010, 16'h0000, 1'b0, 4'd0, 4'd15, 16'h0000, 4'd4},  // R4 clear reads 0
    '{1'b1, 8'h48, 16'hFFFF, 16'h0001, 1'b0, 4'd0, 4'd15, 16'h0020, 4'd10}, // R10 RO, R9 req0, R4 zeros kept
    '{1'b1, 8'h54, 16'h0000, 16'h0000, 1'b0, 4'd0, 4'd0,  16'h0000, 4'd5},  // R5 unforce
    '{1'b1, 8'h4C, 16'h0000, 16'h0000, 1'b0, 4'd0, 4'd5,  16'h0000, 4'd3},  // R3 unmask
    '{1'b0, 8'h48, 16'h0000, 16'h0204, 1'b0, 4'd0, 4'd9,  16'h0224, 4'd6},  // R6 priority
    '{1'b0, 8'h48, 16'h0000, 16'h0000, 1'b1, 4'd9, 4'd9,  16'h0224, 4'd7},  // R7 ack sampled
    '{1'b0, 8'h48, 16'h0000, 16'h0000, 1'b0, 4'd0, 4'd5,  16'h0024, 4'd7},  // R7 cleared next edge
    '{1'b0, 8'h48, 16'h0000, 16'h0000, 1'b1, 4'd5, 4'd5,  16'h0024, 4'd7},  // R7 ack 5
    '{1'b0, 8'h48, 16'h0000, 16'h0020, 1'b0, 4'd0, 4'd5,  16'h0024, 4'd8},  // R8 req beats ack clear
    '{1'b1, 8'h50, 16'h0024, 16'h0004, 1'b0, 4'd0, 4'd2,  16'h0000, 4'd8},  // R8 req beats write clear
    '{1'b0, 8'h48, 16'h0000, 16'h0000, 1'b0, 4'd0, 4'd2,  16'h0004, 4'd8},  // R8 readback
    '{1'b1, 8'h4C, 16'hFFFF, 16'h0000, 1'b0, 4'd0, 4'd0,  16'hFFFE, 4'd9},  // R9 mask bit0
    '{1'b1, 8'h4C, 16'h0000, 16'h0000, 1'b0, 4'd0, 4'd2,  16'h0000, 4'd3},  // R3 unmask
    '{1'b1, 8'h54, 16'h0008, 16'h0000, 1'b0, 4'd0, 4'd3,  16'h0008, 4'd5},  // R5 force only
    '{1'b0, 8'h54, 16'h0000, 16'h0000, 1'b1, 4'd3, 4'd3,  16'h0008, 4'd7},  // R7 ack forced level
    '{1'b0, 8'h54, 16'h0000, 16'h0000, 1'b0, 4'd0, 4'd3,  16'h0008, 4'd7},  // R7 force untouched
    '{1'b0, 8'h40, 16'h0000, 16'h0000, 1'b0, 4'd0, 4'd3,  16'h0000, 4'd10}  // R10 other offset
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, irq_ack;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] src_req;
  logic [3:0]  ack_level, irq_level;
  int          checks = 0;
  int          failures = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_force_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_req(src_req), .irq_ack(irq_ack), .ack_level(ack_level), .irq_level(irq_level)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    src_req = '0; irq_ack = 1'b0; ack_level = '0;
  endtask

  task automatic read_all_zero(input string tag);
    foreach (VEC[0].addr[b]) begin end
    bus_addr = 8'h48; #1 check({tag, " pend"},  bus_rdata, 32'h0);
    bus_addr = 8'h4C; #1 check({tag, " mask"},  bus_rdata, 32'h0);
    bus_addr = 8'h54; #1 check({tag, " force"}, bus_rdata, 32'h0);
    check({tag, " level"}, {28'h0, irq_level}, 32'h0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    read_all_zero("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_all_zero("R1 after release");

    for (int i = 0; i < NV; i++) begin
      bus_sel   = 1'b1;
      bus_wr    = VEC[i].wr;
      bus_addr  = VEC[i].addr;
      bus_wdata = {16'h0, VEC[i].wd};
      src_req   = VEC[i].req;
      irq_ack   = VEC[i].ack;
      ack_level = VEC[i].alvl;
      @(negedge clk);
      bus_wr = 1'b0;
      #1;
      check($sformatf("R%0d vec%0d level", VEC[i].rq, i), {28'h0, irq_level}, {28'h0, VEC[i].elvl});
      check($sformatf("R%0d vec%0d rdata", VEC[i].rq, i), bus_rdata, {16'h0, VEC[i].erd});
    end

    // R1: reset in the middle of activity wipes all state
    idle_inputs();
    rst_n = 1'b0;
    #1;
    read_all_zero("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_all_zero("R1 after mid-run release");

    // R2: fresh request after reset, lowest real level
    src_req = 16'h0002;
    @(negedge clk);
    src_req = '0;
    #1 check("R2 level1 after reset", {28'h0, irq_level}, 32'd1);
    repeat (2) @(negedge clk);
    check("R2 level1 held", {28'h0, irq_level}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule